// File: doc/BRIEF.md
# Threshold-Gated Local Maximum Finder

This block watches one continuous stream of signed samples, one sample per cycle in which the valid strobe is high. It finds every local maximum that climbs above a programmable noise floor. A three-state machine drives the search. In the idle (baseline) state it ignores the stream until a sample is both above the floor and higher than the sample before it. In the rising state it follows the run for as long as each sample is strictly higher than the previous one. When the run stops climbing, the machine spends one clock in the capture state and reports the top of the run.

Each report has three parts: the peak value, the sample index of that peak, and a single-cycle valid pulse. The index comes from a free-running counter of accepted samples. The block has to see one sample past the peak before it knows the peak has ended, so a report always appears one sample after the peak itself. After a report the machine returns to baseline. If the stream is still above the floor, the next rise starts a new peak at once, without the stream first dropping below the floor.

Top module: `thr_peak_finder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `pk_vld`=0, `pk_value`=0 and `pk_index`=0. The sample counter restarts, so the first valid sample after reset has index 0. The comparison for that first sample treats the previous sample as the most negative representable value.
- R2: In baseline, no rise starts unless the sample is strictly greater than `noise_thr`. A sample equal to the threshold, or below it, produces no report.
- R3: A rise starts on a sample that is greater than the threshold and greater than the previous valid sample. The rise continues while each new valid sample is strictly greater than the one before it. The reported value is the last sample of that strictly increasing run.
- R4: The report is triggered by the first valid sample that is not greater than its predecessor. `pk_vld` goes high in the clock cycle right after the cycle that presented that sample, and it stays high for exactly one cycle.
- R5: Equal consecutive samples do not count as rising. A flat top is reported once, with the value and index of its first sample.
- R6: After a report, a sample that is still above the threshold and greater than its predecessor starts a new rise. The stream does not have to fall below the threshold first.
- R7: `pk_index` is the position of the peak sample among valid samples, counted from 0 after reset and wrapping modulo 2^IDX_W. Cycles with `smp_vld` low neither advance the count nor change the search state.
- R8: Between reports, `pk_value` and `pk_index` hold the values of the last report.
- R9: Samples and threshold are compared as two's-complement signed numbers, so negative thresholds and negative peaks work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; `smp_data` is taken when high |
| smp_data | input | DATA_W | Signed sample |
| noise_thr | input | DATA_W | Signed noise floor; a rise needs a sample strictly above it |
| pk_vld | output | 1 | One-cycle pulse marking a new report |
| pk_value | output | DATA_W | Signed value of the last reported peak |
| pk_index | output | IDX_W | Sample index of the last reported peak |

## Verification
The bench builds the block with DATA_W=8 and IDX_W=8. The narrow data width means random draws often hit the extreme signed codes and equal neighbours, which exercises the sign handling and flat tops. The narrow index means a few hundred samples are enough to wrap the sample counter, so the modulo behaviour of the index is checked. Random phases mix strobe gaps, threshold changes and both random-walk and jumpy data. Directed runs cover thresholds hit exactly, plateaus, re-rises that stay above the floor, negative levels and a reset in mid-stream.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

  typedef enum logic [1:0] {
    ST_BASE = 2'd0,
    ST_RISE = 2'd1,
    ST_CAPT = 2'd2
  } pkd_state_e;

endpackage

// File: rtl/pkd_sample_track.sv
module pkd_sample_track #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic signed [DATA_W-1:0] prev_data,
  output logic        [IDX_W-1:0]  cur_idx
);

  localparam logic signed [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic        [IDX_W-1:0]  IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic signed [DATA_W-1:0] prev_q;
  logic        [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= MIN_VAL;
      idx_q  <= '0;
    end else if (smp_vld) begin
      prev_q <= smp_data;
      idx_q  <= idx_q + IDX_ONE;
    end
  end

  assign prev_data = prev_q;
  assign cur_idx   = idx_q;

endmodule

// File: rtl/pkd_slope_fsm.sv
module pkd_slope_fsm
  import pkd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic signed [DATA_W-1:0] noise_thr,
  input  logic signed [DATA_W-1:0] prev_data,
  input  logic        [IDX_W-1:0]  cur_idx,
  output logic                     cap_fire,
  output logic signed [DATA_W-1:0] cand_val,
  output logic        [IDX_W-1:0]  cand_idx
);

  pkd_state_e state_q, state_d;
  logic signed [DATA_W-1:0] cand_val_q;
  logic        [IDX_W-1:0]  cand_idx_q;
  logic rising, above, take;

  assign rising = smp_data > prev_data;
  assign above  = smp_data > noise_thr;

  always_comb begin
    state_d  = state_q;
    cap_fire = 1'b0;
    take     = 1'b0;
    unique case (state_q)
      ST_RISE: begin
        if (smp_vld) begin
          if (rising) begin
            take = 1'b1;
          end else begin
            cap_fire = 1'b1;
            state_d  = ST_CAPT;
          end
        end
      end
      default: begin
        // capture lasts one clock; a sample in that clock is judged as in baseline
        if (state_q == ST_CAPT) state_d = ST_BASE;
        if (smp_vld && above && rising) begin
          take    = 1'b1;
          state_d = ST_RISE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_BASE;
      cand_val_q <= '0;
      cand_idx_q <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        cand_val_q <= smp_data;
        cand_idx_q <= cur_idx;
      end
    end
  end

  assign cand_val = cand_val_q;
  assign cand_idx = cand_idx_q;

endmodule

// File: rtl/pkd_report.sv
module pkd_report #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_fire,
  input  logic signed [DATA_W-1:0] cand_val,
  input  logic        [IDX_W-1:0]  cand_idx,
  output logic                     pk_vld,
  output logic signed [DATA_W-1:0] pk_value,
  output logic        [IDX_W-1:0]  pk_index
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_vld   <= 1'b0;
      pk_value <= '0;
      pk_index <= '0;
    end else begin
      pk_vld <= cap_fire;
      if (cap_fire) begin
        pk_value <= cand_val;
        pk_index <= cand_idx;
      end
    end
  end

endmodule

// File: rtl/thr_peak_finder.sv
module thr_peak_finder #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic signed [DATA_W-1:0] noise_thr,
  output logic                     pk_vld,
  output logic signed [DATA_W-1:0] pk_value,
  output logic        [IDX_W-1:0]  pk_index
);

  logic signed [DATA_W-1:0] prev_data;
  logic        [IDX_W-1:0]  cur_idx;
  logic                     cap_fire;
  logic signed [DATA_W-1:0] cand_val;
  logic        [IDX_W-1:0]  cand_idx;

  pkd_sample_track #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .prev_data (prev_data),
    .cur_idx   (cur_idx)
  );

  pkd_slope_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .noise_thr (noise_thr),
    .prev_data (prev_data),
    .cur_idx   (cur_idx),
    .cap_fire  (cap_fire),
    .cand_val  (cand_val),
    .cand_idx  (cand_idx)
  );

  pkd_report #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rep (
    .clk      (clk),
    .rst      (rst),
    .cap_fire (cap_fire),
    .cand_val (cand_val),
    .cand_idx (cand_idx),
    .pk_vld   (pk_vld),
    .pk_value (pk_value),
    .pk_index (pk_index)
  );

endmodule

// File: rtl/pkd_checker.sv
module pkd_checker #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     smp_vld,
  input logic signed [DATA_W-1:0] smp_data,
  input logic                     pk_vld,
  input logic signed [DATA_W-1:0] pk_value,
  input logic        [IDX_W-1:0]  pk_index
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pk_vld && pk_value == '0 && pk_index == '0));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pk_vld |=> !pk_vld);

  // R4
  follows_sample_chk: assert property (@(posedge clk) disable iff (rst)
    pk_vld |-> $past(smp_vld));

  // R3
  falling_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    pk_vld |-> ($past(smp_data) <= pk_value));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !pk_vld |-> ($stable(pk_value) && $stable(pk_index)));

endmodule

bind thr_peak_finder pkd_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .smp_data (smp_data),
  .pk_vld   (pk_vld),
  .pk_value (pk_value),
  .pk_index (pk_index)
);

// File: tb/sim_thr_peak_finder.sv
`timescale 1ns/1ps
module sim_thr_peak_finder;

  localparam int DW = 8;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic signed [DW-1:0] noise_thr = '0;
  logic pk_vld;
  logic signed [DW-1:0] pk_value;
  logic [IW-1:0] pk_index;

  always #5 clk = ~clk;

  thr_peak_finder #(.DATA_W(DW), .IDX_W(IW)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .noise_thr(noise_thr), .pk_vld(pk_vld), .pk_value(pk_value), .pk_index(pk_index)
  );

  int total = 0;
  int bad = 0;
  int peaks_seen = 0;

  // reference state derived from the requirements
  logic                 m_rise;
  logic signed [DW-1:0] m_prev, m_cand, e_val;
  logic [IW-1:0]        m_cnt, m_cidx, e_idx;
  logic                 e_vld;

  function automatic logic is_above(input logic signed [DW-1:0] s, input logic signed [DW-1:0] t);
    return s > t;  // R2 / R9: strict, signed
  endfunction

  task automatic model_reset();
    m_rise = 1'b0; m_prev = {1'b1, {(DW-1){1'b0}}}; m_cand = '0;
    m_cnt = '0; m_cidx = '0; e_val = '0; e_idx = '0; e_vld = 1'b0;
  endtask

  task automatic model_step(input logic v, input logic signed [DW-1:0] s,
                            input logic signed [DW-1:0] t);
    e_vld = 1'b0;
    if (v) begin
      if (m_rise) begin
        if (s > m_prev) begin m_cand = s; m_cidx = m_cnt; end
        else begin m_rise = 1'b0; e_vld = 1'b1; e_val = m_cand; e_idx = m_cidx; end
      end else if (is_above(s, t) && s > m_prev) begin
        m_rise = 1'b1; m_cand = s; m_cidx = m_cnt;
      end
      m_prev = s;
      m_cnt  = m_cnt + 1'b1;
    end
  endtask

  task automatic check_out(input string req);
    total++;
    if (pk_vld !== e_vld) begin
      bad++;
      $display("FAIL %s pk_vld actual=%0b expected=%0b at %0t", req, pk_vld, e_vld, $time);
    end
    total++;
    if (pk_value !== e_val || pk_index !== e_idx) begin
      bad++;
      $display("FAIL %s value/index actual=%0d/%0d expected=%0d/%0d at %0t",
               req, pk_value, pk_index, e_val, e_idx, $time);
    end
    if (pk_vld) peaks_seen++;
  endtask

  // called at a negedge: drive, update model, wait a cycle, compare
  task automatic cyc(input logic v, input logic signed [DW-1:0] s, input string req);
    smp_vld = v; smp_data = s;
    model_step(v, s, noise_thr);
    @(negedge clk);
    check_out(req);
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1; smp_vld = 1'b0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check_out(req);
  endtask

  task automatic seq(input int n, input logic signed [DW-1:0] d [16], input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, d[i], req);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic signed [DW-1:0] d [16];
    logic signed [DW-1:0] walk;
    int pk_before;
    void'($urandom(20240611));
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check_out("R1");

    // R2: below and equal to threshold never start a rise
    noise_thr = 8'sd10;
    d = '{8'sd3, 8'sd10, 8'sd10, 8'sd5, 8'sd10, 8'sd2, 0,0,0,0,0,0,0,0,0,0};
    pk_before = peaks_seen;
    seq(6, d, "R2");
    cyc(1'b1, 8'sd0, "R2");
    total++;
    if (peaks_seen != pk_before) begin bad++; $display("FAIL R2 peaks actual=%0d expected=%0d", peaks_seen - pk_before, 0); end

    // R3 / R4: simple rise then fall
    d = '{8'sd5, 8'sd20, 8'sd30, 8'sd40, 8'sd35, 8'sd1, 0,0,0,0,0,0,0,0,0,0};
    seq(6, d, "R3");
    cyc(1'b0, 8'sd0, "R4");

    // R5: flat top reported once at first sample
    d = '{8'sd12, 8'sd50, 8'sd50, 8'sd50, 8'sd20, 8'sd0, 0,0,0,0,0,0,0,0,0,0};
    pk_before = peaks_seen;
    seq(6, d, "R5");
    total++;
    if (peaks_seen - pk_before != 1) begin bad++; $display("FAIL R5 peaks actual=%0d expected=%0d", peaks_seen - pk_before, 1); end

    // R6: re-rise while above threshold
    d = '{8'sd20, 8'sd60, 8'sd45, 8'sd70, 8'sd30, 8'sd31, 8'sd29, 8'sd0, 0,0,0,0,0,0,0,0};
    pk_before = peaks_seen;
    seq(8, d, "R6");
    total++;
    if (peaks_seen - pk_before != 3) begin bad++; $display("FAIL R6 peaks actual=%0d expected=%0d", peaks_seen - pk_before, 3); end

    // R9: negative threshold and levels, extremes
    noise_thr = -8'sd50;
    d = '{-8'sd128, -8'sd100, -8'sd40, -8'sd20, -8'sd60, -8'sd50, -8'sd49, -8'sd128,
          8'sd127, 8'sd127, -8'sd1, 0,0,0,0,0};
    seq(11, d, "R9");

    // R7: strobe gaps do not advance index or state
    noise_thr = 8'sd0;
    cyc(1'b1, 8'sd5, "R7");
    cyc(1'b0, 8'sd100, "R7");
    cyc(1'b1, 8'sd9, "R7");
    cyc(1'b0, -8'sd100, "R7");
    cyc(1'b0, 8'sd1, "R7");
    cyc(1'b1, 8'sd3, "R7");
    cyc(1'b1, -8'sd3, "R8");
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'sd77, "R8");

    // R1: reset mid-rise, index restarts at 0
    cyc(1'b1, 8'sd40, "R1");
    cyc(1'b1, 8'sd41, "R1");
    do_reset("R1");
    d = '{8'sd1, 8'sd2, 0,0,0,0,0,0,0,0,0,0,0,0,0,0};
    seq(3, d, "R1");
    total++;
    if (e_idx != 1 || pk_index !== 8'd1) begin bad++; $display("FAIL R1 index actual=%0d expected=%0d", pk_index, 1); end

    // random phases: index wrap (R7), mixed data
    walk = '0;
    for (int ph = 0; ph < 8; ph++) begin
      noise_thr = $signed(8'($urandom_range(0, 255)));
      if (ph % 2 == 0) noise_thr = $signed(8'($urandom_range(0, 40))) - 8'sd20;
      for (int k = 0; k < 700; k++) begin
        logic v;
        logic signed [DW-1:0] s;
        v = ($urandom_range(0, 3) != 0);
        if (ph % 3 == 0) s = $signed(8'($urandom_range(0, 255)));
        else begin
          walk = walk + $signed(8'($urandom_range(0, 12))) - 8'sd6;
          s = walk;
        end
        if ($urandom_range(0, 99) == 0) noise_thr = $signed(8'($urandom_range(0, 255)));
        cyc(v, s, (k % 2 == 0) ? "R3" : "R7");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule